// File: doc/BRIEF.md
# Buffer-Gated Burst Read Issuer

This block is the read side of a memory client. It takes one read command at a time: a start address and a total number of data beats. It cuts the command into AXI4 INCR bursts, which are never longer than a configured maximum and never cross a 4 KB page. It offers those bursts on the AR channel and writes every returned R beat into a local receive buffer. The buffer reports its free slot count to the block.

Before a burst is offered, the block reserves room for the whole burst in the buffer. It counts every beat of every burst that has been offered but not yet written. A burst is raised only when the free count covers those reserved beats plus the new burst. The number of bursts in flight is also capped. ARVALID is never derived from ARREADY: the block offers a burst when it has one and room for it, and the slave throttles through ARREADY. Several bursts stay in flight, so refresh or other stalls in the memory controller show up only as ARREADY or RVALID backpressure. Any R beat whose response is not OKAY sets a sticky error flag.

Top module: `axi_rd_issuer`

## Requirements
- R1: After reset the following hold: `m_arvalid` is 0, `buf_wr_en` is 0, `rd_err` is 0, `req_ready` is 1, and `m_rready` is 1 while `buf_free` is non-zero.
- R2: While `m_arvalid` is 1 and `m_arready` is 0, on the next cycle `m_arvalid` stays 1 and `m_araddr` and `m_arlen` keep their values.
- R3: `m_arvalid` rises to offer a pending burst while `m_arready` is held at 0 throughout.
- R4: A command is split into bursts. Each burst has min(remaining beats, MAX_BURST) beats, unless R5 shortens it. Bursts are issued in address order at consecutive addresses. On every burst, `m_arlen` = beats−1, `m_arsize` = log2(DATA_W/8) (2 for 32-bit data), `m_arburst` = 2'b01 (incrementing) and `m_arid` = RD_ID.
- R5: No burst crosses a 4 KB boundary. A burst that would cross one ends at the boundary, and the next burst starts there.
- R6: A burst is offered only if `buf_free` ≥ (beats of earlier offered bursts not yet written) + (its own beats). When the buffer is never drained, the total beats issued never exceed the buffer depth.
- R7: At most MAX_OUTST bursts (default 4) are in flight, counted from offer to their RLAST beat. When the cap is reached, `m_arvalid` stays 0.
- R8: `m_rready` equals (`buf_free` != 0). On every R handshake, `buf_wr_en` is 1 in the same cycle and `buf_wr_data` equals `m_rdata`, in arrival order.
- R9: An accepted R beat with `m_rresp` != 2'b00 sets `rd_err`. It stays set until reset, even after later OKAY beats.
- R10: A command is taken when `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from that point until the last burst of the command has been loaded for issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Read command present |
| req_addr | input | ADDR_W | Start byte address, aligned to the beat size |
| req_beats | input | CNT_W | Total beats to read |
| req_ready | output | 1 | Command can be taken |
| m_arvalid | output | 1 | AR channel valid |
| m_arready | input | 1 | AR channel ready |
| m_araddr | output | ADDR_W | Burst start address |
| m_arlen | output | 8 | Burst beats minus one |
| m_arsize | output | 3 | Beat size code |
| m_arburst | output | 2 | Burst type, always incrementing |
| m_arid | output | ID_W | Fixed transaction ID |
| m_rvalid | input | 1 | R channel valid |
| m_rready | output | 1 | R channel ready |
| m_rdata | input | DATA_W | Read data |
| m_rresp | input | 2 | Read response |
| m_rlast | input | 1 | Last beat of a burst |
| buf_free | input | $clog2(BUF_DEPTH+1) | Free slots in the receive buffer |
| buf_wr_en | output | 1 | Buffer write strobe |
| buf_wr_data | output | DATA_W | Buffer write data |
| rd_err | output | 1 | Sticky error response flag |

## Verification
Suppose the reserved-beat count drifts low. The damage is seen only when the buffer is not drained: the total beats issued passes the buffer depth within one burst, and `m_rready` then drops while the slave still holds data. If the count drifts high, the block stalls with `m_arvalid` low even though the buffer has room, and a command never completes. A wrong burst-count limit shows within a few cycles as a fifth burst accepted while no data has returned. A splitter fault shows at once on `m_araddr` or `m_arlen` of the first affected burst.

// File: rtl/rdq_pkg.sv
`timescale 1ns/1ps
package rdq_pkg;
  localparam logic [1:0]  AXI_BURST_INCR = 2'b01;
  localparam logic [1:0]  AXI_RESP_OKAY  = 2'b00;
  localparam int unsigned AXI_LEN_W      = 8;
  localparam int unsigned PAGE_BYTES     = 4096;
endpackage

// File: rtl/rdq_split.sv
`timescale 1ns/1ps
// Cuts one command into page-safe bursts of bounded length.
module rdq_split #(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16,
  parameter int BLEN_W     = 4,
  parameter int MAX_BURST  = 8,
  parameter int BEAT_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]  req_beats,
  output logic              req_ready,
  output logic              nb_valid,
  output logic [ADDR_W-1:0] nb_addr,
  output logic [BLEN_W-1:0] nb_beats,
  input  logic              take
);
  localparam int PAGE_W = $clog2(rdq_pkg::PAGE_BYTES);

  // beats of the next burst: remaining, capped by burst limit and page room
  function automatic logic [BLEN_W-1:0] burst_len(input logic [CNT_W-1:0] left,
                                                   input logic [PAGE_W-1:0] off);
    logic [31:0] room;
    logic [31:0] pick;
    room = (32'(rdq_pkg::PAGE_BYTES) - 32'(off)) / 32'(BEAT_BYTES);
    pick = 32'(left);
    if (pick > 32'(MAX_BURST)) pick = 32'(MAX_BURST);
    if (pick > room) pick = room;
    return BLEN_W'(pick);
  endfunction

  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a,
                                                   input logic [BLEN_W-1:0] n);
    return a + ADDR_W'(32'(n) * 32'(BEAT_BYTES));
  endfunction

  logic              busy_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  left_q;
  logic              cmd_accept;
  logic              last_take;

  assign cmd_accept = req_valid && !busy_q;
  assign nb_beats   = burst_len(left_q, addr_q[PAGE_W-1:0]);
  assign nb_valid   = busy_q;
  assign nb_addr    = addr_q;
  assign req_ready  = !busy_q;
  assign last_take  = take && (left_q == CNT_W'(nb_beats));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      addr_q <= '0;
      left_q <= '0;
    end else if (cmd_accept) begin
      busy_q <= (req_beats != '0);
      addr_q <= req_addr;
      left_q <= req_beats;
    end else if (take) begin
      busy_q <= !last_take;
      addr_q <= step_addr(addr_q, nb_beats);
      left_q <= left_q - CNT_W'(nb_beats);
    end
  end

  AST_PAGE_SAFE: assert property (@(posedge clk) disable iff (!rst_n) nb_valid |-> (32'(addr_q[PAGE_W-1:0]) + 32'(nb_beats) * 32'(BEAT_BYTES)) <= 32'(rdq_pkg::PAGE_BYTES)); // R5
  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) nb_valid |-> (nb_beats != '0) && (32'(nb_beats) <= 32'(MAX_BURST))); // R4
  AST_TAKE_PENDING: assert property (@(posedge clk) disable iff (!rst_n) take |-> nb_valid); // R4
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n) busy_q && !last_take |=> !req_ready); // R10
endmodule

// File: rtl/rdq_credit.sv
`timescale 1ns/1ps
// Reserves buffer room per burst and limits bursts in flight.
module rdq_credit #(
  parameter int FREE_W    = 7,
  parameter int BLEN_W    = 4,
  parameter int MAX_OUTST = 4,
  parameter int OB_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FREE_W-1:0] buf_free,
  input  logic              want,
  input  logic [BLEN_W-1:0] want_beats,
  input  logic              load,
  input  logic              beat,
  input  logic              burst_end,
  output logic              grant,
  output logic [OB_W-1:0]   open_bursts
);
  function automatic logic room_ok(input logic [FREE_W-1:0] free,
                                   input logic [FREE_W-1:0] held,
                                   input logic [BLEN_W-1:0] need);
    return 32'(free) >= (32'(held) + 32'(need));
  endfunction

  logic [FREE_W-1:0] held_q;
  logic [OB_W-1:0]   open_q;
  logic              cap_hit;
  logic              fits;

  assign cap_hit     = (open_q >= OB_W'(MAX_OUTST));
  assign fits        = room_ok(buf_free, held_q, want_beats);
  assign grant       = want && !cap_hit && fits;
  assign open_bursts = open_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= '0;
      open_q <= '0;
    end else begin
      held_q <= held_q + (load ? FREE_W'(want_beats) : '0) - (beat ? FREE_W'(1) : '0);
      open_q <= open_q + (load ? OB_W'(1) : '0) - (burst_end ? OB_W'(1) : '0);
    end
  end

  AST_CAP: assert property (@(posedge clk) disable iff (!rst_n) open_q <= OB_W'(MAX_OUTST)); // R7
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) beat |-> held_q != '0); // R6
  AST_RESERVE_FITS: assert property (@(posedge clk) disable iff (!rst_n) held_q <= buf_free); // R6
  AST_LOAD_GRANTED: assert property (@(posedge clk) disable iff (!rst_n) load |-> grant); // R6
endmodule

// File: rtl/rdq_ar.sv
`timescale 1ns/1ps
// AR channel holding register; valid never derived from ready.
module rdq_ar #(
  parameter int         ADDR_W    = 32,
  parameter int         ID_W      = 4,
  parameter int         BLEN_W    = 4,
  parameter logic [2:0] SIZE_CODE = 3'd2,
  parameter int         RD_ID     = 3
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              offer,
  input  logic [ADDR_W-1:0]                 nb_addr,
  input  logic [BLEN_W-1:0]                 nb_beats,
  input  logic                              arready,
  output logic                              load,
  output logic                              arvalid,
  output logic [ADDR_W-1:0]                 araddr,
  output logic [rdq_pkg::AXI_LEN_W-1:0]     arlen,
  output logic [2:0]                        arsize,
  output logic [1:0]                        arburst,
  output logic [ID_W-1:0]                   arid
);
  localparam int LW = rdq_pkg::AXI_LEN_W;

  logic              valid_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LW-1:0]     len_q;
  logic              slot_free;

  // slot reloads only when idle or on a completed handshake
  assign slot_free = !valid_q || arready;
  assign load      = offer && slot_free;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      len_q   <= '0;
    end else if (load) begin
      valid_q <= 1'b1;
      addr_q  <= nb_addr;
      len_q   <= LW'(nb_beats) - LW'(1);
    end else if (slot_free) begin
      valid_q <= 1'b0;
    end
  end

  assign arvalid = valid_q;
  assign araddr  = addr_q;
  assign arlen   = len_q;
  assign arsize  = SIZE_CODE;
  assign arburst = rdq_pkg::AXI_BURST_INCR;
  assign arid    = ID_W'(RD_ID);

  AST_AR_HOLD: assert property (@(posedge clk) disable iff (!rst_n) valid_q && !arready |=> valid_q && $stable(addr_q) && $stable(len_q)); // R2
  AST_RISE_OFFERED: assert property (@(posedge clk) disable iff (!rst_n) $rose(valid_q) |-> $past(offer)); // R6
endmodule

// File: rtl/rdq_rbeat.sv
`timescale 1ns/1ps
// R channel acceptance, buffer write and sticky error.
module rdq_rbeat #(
  parameter int DATA_W = 32,
  parameter int FREE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rvalid,
  input  logic [DATA_W-1:0] rdata,
  input  logic [1:0]        rresp,
  input  logic              rlast,
  input  logic [FREE_W-1:0] buf_free,
  output logic              rready,
  output logic              beat,
  output logic              burst_end,
  output logic              buf_wr_en,
  output logic [DATA_W-1:0] buf_wr_data,
  output logic              rd_err
);
  logic err_q;
  logic bad_beat;

  assign rready      = (buf_free != '0);
  assign beat        = rvalid && rready;
  assign burst_end   = beat && rlast;
  assign bad_beat    = beat && (rresp != rdq_pkg::AXI_RESP_OKAY);
  assign buf_wr_en   = beat;
  assign buf_wr_data = rdata;
  assign rd_err      = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else if (bad_beat) err_q <= 1'b1;
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) err_q |=> err_q); // R9
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(err_q) |-> $past(rvalid) && $past(rresp) != rdq_pkg::AXI_RESP_OKAY); // R9
endmodule

// File: rtl/axi_rd_issuer.sv
`timescale 1ns/1ps
module axi_rd_issuer #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int ID_W      = 4,
  parameter int RD_ID     = 3,
  parameter int CNT_W     = 16,
  parameter int MAX_BURST = 8,
  parameter int BUF_DEPTH = 64,
  parameter int MAX_OUTST = 4,
  parameter int FREE_W    = $clog2(BUF_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]  req_beats,
  output logic              req_ready,
  output logic              m_arvalid,
  input  logic              m_arready,
  output logic [ADDR_W-1:0] m_araddr,
  output logic [7:0]        m_arlen,
  output logic [2:0]        m_arsize,
  output logic [1:0]        m_arburst,
  output logic [ID_W-1:0]   m_arid,
  input  logic              m_rvalid,
  output logic              m_rready,
  input  logic [DATA_W-1:0] m_rdata,
  input  logic [1:0]        m_rresp,
  input  logic              m_rlast,
  input  logic [FREE_W-1:0] buf_free,
  output logic              buf_wr_en,
  output logic [DATA_W-1:0] buf_wr_data,
  output logic              rd_err
);
  localparam int         BEAT_BYTES = DATA_W / 8;
  localparam int         BLEN_W     = $clog2(MAX_BURST + 1);
  localparam int         OB_W       = $clog2(MAX_OUTST + 1);
  localparam logic [2:0] SIZE_CODE  = 3'($clog2(BEAT_BYTES));

  // named internal events
  logic              nb_valid;
  logic [ADDR_W-1:0] nb_addr;
  logic [BLEN_W-1:0] nb_beats;
  logic              grant;
  logic              ar_load;
  logic              r_beat;
  logic              r_burst_end;
  logic [OB_W-1:0]   open_bursts;

  rdq_split #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .BLEN_W(BLEN_W),
    .MAX_BURST(MAX_BURST), .BEAT_BYTES(BEAT_BYTES)
  ) u_split (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_addr(req_addr), .req_beats(req_beats), .req_ready(req_ready),
    .nb_valid(nb_valid), .nb_addr(nb_addr), .nb_beats(nb_beats), .take(ar_load)
  );

  rdq_credit #(
    .FREE_W(FREE_W), .BLEN_W(BLEN_W), .MAX_OUTST(MAX_OUTST), .OB_W(OB_W)
  ) u_credit (
    .clk(clk), .rst_n(rst_n), .buf_free(buf_free),
    .want(nb_valid), .want_beats(nb_beats), .load(ar_load),
    .beat(r_beat), .burst_end(r_burst_end),
    .grant(grant), .open_bursts(open_bursts)
  );

  rdq_ar #(
    .ADDR_W(ADDR_W), .ID_W(ID_W), .BLEN_W(BLEN_W), .SIZE_CODE(SIZE_CODE), .RD_ID(RD_ID)
  ) u_ar (
    .clk(clk), .rst_n(rst_n), .offer(grant), .nb_addr(nb_addr), .nb_beats(nb_beats),
    .arready(m_arready), .load(ar_load), .arvalid(m_arvalid), .araddr(m_araddr),
    .arlen(m_arlen), .arsize(m_arsize), .arburst(m_arburst), .arid(m_arid)
  );

  rdq_rbeat #(
    .DATA_W(DATA_W), .FREE_W(FREE_W)
  ) u_rbeat (
    .clk(clk), .rst_n(rst_n), .rvalid(m_rvalid), .rdata(m_rdata), .rresp(m_rresp),
    .rlast(m_rlast), .buf_free(buf_free), .rready(m_rready), .beat(r_beat),
    .burst_end(r_burst_end), .buf_wr_en(buf_wr_en), .buf_wr_data(buf_wr_data), .rd_err(rd_err)
  );

  AST_R_EXPECTED: assert property (@(posedge clk) disable iff (!rst_n) r_beat |-> open_bursts != '0); // R8
  AST_LOAD_HAS_CMD: assert property (@(posedge clk) disable iff (!rst_n) ar_load |-> !req_ready); // R10
endmodule

// File: tb/tb_axi_rd_issuer.sv
`timescale 1ns/1ps
module tb_axi_rd_issuer;
  localparam int DEPTH = 64;
  localparam int CAP   = 4;
  localparam int RDID  = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [15:0] req_beats = '0;
  logic        req_ready;
  logic        m_arvalid;
  logic        m_arready = 1'b0;
  logic [31:0] m_araddr;
  logic [7:0]  m_arlen;
  logic [2:0]  m_arsize;
  logic [1:0]  m_arburst;
  logic [3:0]  m_arid;
  logic        m_rvalid = 1'b0;
  logic        m_rready;
  logic [31:0] m_rdata = '0;
  logic [1:0]  m_rresp = '0;
  logic        m_rlast = 1'b0;
  logic [6:0]  buf_free = 7'(DEPTH);
  logic        buf_wr_en;
  logic [31:0] buf_wr_data;
  logic        rd_err;

  axi_rd_issuer dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_beats(req_beats), .req_ready(req_ready), .m_arvalid(m_arvalid),
    .m_arready(m_arready), .m_araddr(m_araddr), .m_arlen(m_arlen), .m_arsize(m_arsize),
    .m_arburst(m_arburst), .m_arid(m_arid), .m_rvalid(m_rvalid), .m_rready(m_rready),
    .m_rdata(m_rdata), .m_rresp(m_rresp), .m_rlast(m_rlast), .buf_free(buf_free),
    .buf_wr_en(buf_wr_en), .buf_wr_data(buf_wr_data), .rd_err(rd_err)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  // slave and buffer model state
  bit          ar_en = 1'b0;
  bit          r_hold = 1'b0;
  bit          drain_en = 1'b1;
  int          err_at = -1;
  int          free_m = DEPTH;
  int          written = 0;
  int          acc_unwritten = 0;
  int          bursts_open = 0;
  int          beat_idx = 0;
  logic [31:0] data_cnt = 32'h1000_0000;
  int          q_len[$];
  logic [31:0] log_addr[$];
  int          log_len[$];
  bit          prev_stall = 1'b0;
  logic [31:0] prev_addr = '0;
  logic [7:0]  prev_len = '0;

  task automatic check(input bit ok, input string req, input string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s", req, what);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // slave + buffer model: drive at negedge, observe handshakes just after
  initial begin
    forever begin
      @(negedge clk);
      if (prev_stall)
        check(m_arvalid && m_araddr == prev_addr && m_arlen == prev_len, "R2",
              $sformatf("held AR got v=%0b a=%h l=%0d exp v=1 a=%h l=%0d",
                        m_arvalid, m_araddr, m_arlen, prev_addr, prev_len));
      m_arready = ar_en;
      if (q_len.size() > 0 && !r_hold) begin
        m_rvalid = 1'b1;
        m_rdata  = data_cnt;
        m_rlast  = (beat_idx == q_len[0] - 1);
        m_rresp  = (err_at >= 0 && data_cnt == 32'(err_at)) ? 2'b10 : 2'b00;
      end else begin
        m_rvalid = 1'b0;
        m_rlast  = 1'b0;
        m_rresp  = 2'b00;
      end
      buf_free = 7'(free_m);
      #1;
      prev_stall = rst_n && m_arvalid && !m_arready;
      prev_addr  = m_araddr;
      prev_len   = m_arlen;
      if (rst_n && m_arvalid && m_arready) begin
        check(acc_unwritten + int'(m_arlen) + 1 <= free_m, "R6",
              $sformatf("reserved+len got %0d exp <= free %0d", acc_unwritten + int'(m_arlen) + 1, free_m));
        check(bursts_open < CAP, "R7", $sformatf("open bursts got %0d exp < %0d", bursts_open, CAP));
        check(m_arid == 4'(RDID) && m_arsize == 3'd2 && m_arburst == 2'b01, "R4",
              $sformatf("id/size/burst got %0d/%0d/%0d exp %0d/2/1", m_arid, m_arsize, m_arburst, RDID));
        q_len.push_back(int'(m_arlen) + 1);
        log_addr.push_back(m_araddr);
        log_len.push_back(int'(m_arlen));
        acc_unwritten += int'(m_arlen) + 1;
        bursts_open++;
      end
      if (rst_n && m_rvalid && m_rready) begin
        check(buf_wr_en && buf_wr_data == m_rdata, "R8",
              $sformatf("write got en=%0b d=%h exp en=1 d=%h", buf_wr_en, buf_wr_data, m_rdata));
        free_m--;
        acc_unwritten--;
        written++;
        data_cnt++;
        if (m_rlast) begin
          void'(q_len.pop_front());
          bursts_open--;
          beat_idx = 0;
        end else beat_idx++;
      end else begin
        if (buf_wr_en) check(1'b0, "R8", "write got en=1 exp en=0 without handshake");
        if (drain_en && free_m < DEPTH) free_m++;
      end
    end
  end

  task automatic send_cmd(input logic [31:0] a, input int n);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    req_beats = 16'(n);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle(input int target, input string req);
    int n = 0;
    while (!(written >= target && q_len.size() == 0 && !m_arvalid && req_ready) && n < 5000) begin
      @(negedge clk);
      n++;
    end
    check(n < 5000, req, $sformatf("completion: written got %0d exp %0d", written, target));
    n = 0;
    while (free_m != DEPTH && n < 500) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic exp_burst(input int idx, input logic [31:0] a, input int l, input string req);
    check(log_addr[idx] == a && log_len[idx] == l, req,
          $sformatf("burst %0d got %h/len %0d exp %h/len %0d", idx, log_addr[idx], log_len[idx], a, l));
  endtask

  task automatic t_reset();
    check(!m_arvalid && !buf_wr_en && !rd_err && req_ready && m_rready, "R1",
          $sformatf("got arv=%0b wr=%0b err=%0b rqr=%0b rr=%0b exp 0/0/0/1/1",
                    m_arvalid, buf_wr_en, rd_err, req_ready, m_rready));
  endtask

  task automatic t_no_ready_dep();
    int w0 = written;
    ar_en = 1'b0;
    send_cmd(32'h0000_0040, 4);
    repeat (2) @(negedge clk);
    check(m_arvalid && !m_arready, "R3", $sformatf("arvalid got %0b exp 1 with arready 0", m_arvalid));
    repeat (5) @(negedge clk);
    check(m_arvalid && m_araddr == 32'h40 && m_arlen == 8'd3, "R2",
          $sformatf("stalled AR got %h/%0d exp 40/3", m_araddr, m_arlen));
    ar_en = 1'b1;
    wait_idle(w0 + 4, "R3");
  endtask

  task automatic t_split();
    int base = log_addr.size();
    int w0 = written;
    send_cmd(32'h0000_0100, 20);
    check(!req_ready, "R10", $sformatf("req_ready after accept got %0b exp 0", req_ready));
    wait_idle(w0 + 20, "R4");
    check(log_addr.size() - base == 3, "R4", $sformatf("burst count got %0d exp 3", log_addr.size() - base));
    if (log_addr.size() - base == 3) begin
      exp_burst(base,     32'h100, 7, "R4");
      exp_burst(base + 1, 32'h120, 7, "R4");
      exp_burst(base + 2, 32'h140, 3, "R4");
    end
    check(req_ready, "R10", $sformatf("req_ready after all bursts got %0b exp 1", req_ready));
  endtask

  task automatic t_page();
    int base = log_addr.size();
    int w0 = written;
    send_cmd(32'h0000_0FF0, 8);
    wait_idle(w0 + 8, "R5");
    check(log_addr.size() - base == 2, "R5", $sformatf("burst count got %0d exp 2", log_addr.size() - base));
    if (log_addr.size() - base == 2) begin
      exp_burst(base,     32'h0FF0, 3, "R5");
      exp_burst(base + 1, 32'h1000, 3, "R5");
    end
  endtask

  task automatic t_cap();
    int base = log_addr.size();
    int w0 = written;
    r_hold = 1'b1;
    send_cmd(32'h0000_2000, 64);
    repeat (40) @(negedge clk);
    check(log_addr.size() - base == CAP, "R7", $sformatf("bursts with no data got %0d exp %0d", log_addr.size() - base, CAP));
    check(!m_arvalid, "R7", $sformatf("arvalid at cap got %0b exp 0", m_arvalid));
    r_hold = 1'b0;
    wait_idle(w0 + 64, "R7");
    check(log_addr.size() - base == 8, "R4", $sformatf("total bursts got %0d exp 8", log_addr.size() - base));
  endtask

  task automatic t_gate();
    int base = log_addr.size();
    int w0 = written;
    drain_en = 1'b0;
    send_cmd(32'h0000_3000, 80);
    repeat (300) @(negedge clk);
    check(written - w0 == DEPTH, "R6", $sformatf("beats written undrained got %0d exp %0d", written - w0, DEPTH));
    check(log_addr.size() - base == 8, "R6", $sformatf("bursts undrained got %0d exp 8", log_addr.size() - base));
    check(!m_arvalid, "R6", $sformatf("arvalid with full buffer got %0b exp 0", m_arvalid));
    check(!m_rready, "R8", $sformatf("rready with free 0 got %0b exp 0", m_rready));
    drain_en = 1'b1;
    repeat (3) @(negedge clk);
    check(m_rready, "R8", $sformatf("rready with free>0 got %0b exp 1", m_rready));
    wait_idle(w0 + 80, "R6");
  endtask

  task automatic t_err();
    int w0 = written;
    check(!rd_err, "R9", $sformatf("rd_err before error got %0b exp 0", rd_err));
    err_at = int'(data_cnt) + 2;
    send_cmd(32'h0000_4000, 4);
    wait_idle(w0 + 4, "R9");
    check(rd_err, "R9", $sformatf("rd_err after SLVERR got %0b exp 1", rd_err));
    err_at = -1;
    send_cmd(32'h0000_4100, 4);
    wait_idle(w0 + 8, "R9");
    check(rd_err, "R9", $sformatf("rd_err after OKAY beats got %0b exp 1", rd_err));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: cycles got 150000 exp completion earlier");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    t_reset();
    t_no_ready_dep();
    t_split();
    t_page();
    t_cap();
    t_gate();
    t_err();
    finish_run();
  end
endmodule